// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash device. It decides whether a program or erase operation that software has already started has finished, failed or been suspended. A one-cycle `go_i` pulse starts a poll on a given status address. From then on the block reads status bytes over a simple request/acknowledge byte-read port. It looks at how the status bits behave from one read to the next and ends with exactly one verdict pulse, carrying the byte that decided it.

Each poll step is a pair of back-to-back reads. When the toggle bit (bit 6) is the same in both reads of a pair, the device has stopped working, and the block makes one more read to fetch valid array data. When bit 6 changes and the timing-limit flag (bit 5) is low, the block starts another pair. When bit 5 is high, the block re-reads once more as a pair, because the toggle may have stopped just as the flag rose. For erase polls, a steady bit 6 with a changing bit 2 means the sector is suspended, not finished. A parameterised cap on the number of pairs ends a poll that never settles.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, `busy_o`, `rd_req_o`, `done_o`, `fail_o` and `susp_o` are all low.
- R2: A `go_i` pulse while idle raises `busy_o` on the next cycle. Every read is made at the address latched with `go_i`. `rd_req_o` stays high until the cycle in which `rd_ack_i` is seen, and `rd_data_i` is sampled in that cycle.
- R3: If bit 6 is equal in the two reads of a pair and no suspend is detected, exactly one more read is made, and `done_o` pulses with that read's byte on `result_o`.
- R4: If bit 6 differs within a pair and bit 5 of the pair's second byte is 0, a new pair of reads begins.
- R5: If bit 6 differs within a pair and bit 5 of the second byte is 1, a recheck pair is read. If bit 6 is equal in the recheck pair, the R3 completion path follows.
- R6: If bit 6 still differs in the recheck pair, `fail_o` pulses with the recheck's second byte on `result_o`.
- R7: After `MAX_PAIRS` pairs in a row in which bit 6 differs and bit 5 is 0, `fail_o` pulses with the last byte read, whatever bit 5 shows.
- R8: When `erase_i` was high at `go_i`, bit 6 is equal within a pair and bit 2 differs, `susp_o` pulses with the pair's second byte, and no further read is made. With `erase_i` low, bit 2 is ignored and R3 applies.
- R9: A pair in which both bit 6 and bit 2 differ counts as active erasing, and polling continues as in R4.
- R10: Each poll ends with exactly one one-cycle pulse on one of `done_o`, `fail_o` or `susp_o`. `busy_o` falls in the same cycle that pulse is high.
- R11: A `go_i` pulse while `busy_o` is high has no effect on the address, the read count or the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Start pulse for a poll |
| addr_i | input | ADDR_W | Status address to poll (inside the target sector for erases) |
| erase_i | input | 1 | Poll belongs to an erase; enables suspend classification |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; data valid in this cycle |
| rd_data_i | input | DATA_W | Read data |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle pulse: operation complete |
| fail_o | output | 1 | One-cycle pulse: operation failed or pair cap reached |
| susp_o | output | 1 | One-cycle pulse: sector erase-suspended |
| result_o | output | DATA_W | Byte behind the latest verdict |

## Verification
The assertions assume the read responder behaves: it raises `rd_ack_i` only while `rd_req_o` is high, holds it for a single cycle, and never acknowledges in the cycle after an acknowledge. The bench responder acts on the falling clock edge. It waits a per-vector latency of zero to three cycles after seeing a request, acknowledges for one cycle, and then drops `rd_ack_i` before it can see a request again. Status bytes come from a per-read-index pattern with set toggle lengths and a set start read for bit 5, so no acknowledge ever arrives without a request.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_A,
      ST_RD_B,
      ST_RC_A,
      ST_RC_B,
      ST_TAIL
   } poll_st_e;

   typedef enum logic [1:0] {
      VD_NONE,
      VD_DONE,
      VD_FAIL,
      VD_SUSP
   } verdict_e;
endpackage

// File: rtl/tpc_rd_port.sv
module tpc_rd_port #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              req_o,
   output logic [ADDR_W-1:0] addr_o,
   input  logic              ack_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              vld_o,
   output logic [DATA_W-1:0] data_o
);
   logic              req_q, vld_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         vld_q  <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         vld_q <= 1'b0;
         if (start_i) begin
            req_q  <= 1'b1;
            addr_q <= addr_i;
         end else if (req_q && ack_i) begin
            req_q  <= 1'b0;
            vld_q  <= 1'b1;
            data_q <= data_i;
         end
      end
   end

   assign req_o  = req_q;
   assign addr_o = addr_q;
   assign vld_o  = vld_q;
   assign data_o = data_q;
endmodule

// File: rtl/tpc_tog_cmp.sv
module tpc_tog_cmp #(
   parameter int DATA_W  = 8,
   parameter int TOG_POS = 6,
   parameter int LIM_POS = 5,
   parameter int SEC_POS = 2,
   parameter bit SEC_EN  = 1'b1
) (
   input  logic [DATA_W-1:0] prev_i,
   input  logic [DATA_W-1:0] cur_i,
   output logic              tog_o,
   output logic              lim_o,
   output logic              sec_tog_o
);
   logic [DATA_W-1:0] diff;
   logic              unused_bits;

   assign diff  = prev_i ^ cur_i;
   assign tog_o = diff[TOG_POS];
   assign lim_o = cur_i[LIM_POS];

   generate
      if (SEC_EN) begin : g_sec
         assign sec_tog_o = diff[SEC_POS];
      end else begin : g_nosec
         assign sec_tog_o = 1'b0;
      end
   endgenerate

   assign unused_bits = ^{diff, cur_i};
endmodule

// File: rtl/tpc_pair_ctr.sv
module tpc_pair_ctr #(
   parameter int MAX_PAIRS = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);
   localparam int CW = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1;
   localparam logic [CW-1:0] LAST = CW'(MAX_PAIRS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (inc_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
   import tpc_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 8,
   parameter int MAX_PAIRS = 1024,
   parameter int TOG_POS   = 6,
   parameter int LIM_POS   = 5,
   parameter int SEC_POS   = 2,
   parameter bit SEC_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              erase_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              fail_o,
   output logic              susp_o,
   output logic [DATA_W-1:0] result_o
);
   generate
      if (MAX_PAIRS < 1) begin : g_bad_max
         $error("MAX_PAIRS must be at least 1");
      end
      if (TOG_POS >= DATA_W || LIM_POS >= DATA_W || SEC_POS >= DATA_W) begin : g_bad_pos
         $error("status bit positions must lie inside DATA_W");
      end
      if (TOG_POS == LIM_POS || TOG_POS == SEC_POS) begin : g_bad_alias
         $error("toggle bit must differ from the flag and sector bits");
      end
   endgenerate

   poll_st_e          state_q, state_d;
   verdict_e          verdict;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] first_q, result_q, rd_byte;
   logic              erase_q, done_q, fail_q, susp_q;
   logic              rd_start, rd_vld, tog, lim, sec_tog, pair_last, go_ok;

   assign go_ok = go_i && (state_q == ST_IDLE);

   tpc_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rd_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(rd_start),
      .addr_i (go_ok ? addr_i : addr_q),
      .req_o  (rd_req_o),
      .addr_o (rd_addr_o),
      .ack_i  (rd_ack_i),
      .data_i (rd_data_i),
      .vld_o  (rd_vld),
      .data_o (rd_byte)
   );

   tpc_tog_cmp #(
      .DATA_W(DATA_W), .TOG_POS(TOG_POS), .LIM_POS(LIM_POS),
      .SEC_POS(SEC_POS), .SEC_EN(SEC_EN)
   ) cmp_i (
      .prev_i   (first_q),
      .cur_i    (rd_byte),
      .tog_o    (tog),
      .lim_o    (lim),
      .sec_tog_o(sec_tog)
   );

   tpc_pair_ctr #(.MAX_PAIRS(MAX_PAIRS)) pair_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (go_ok),
      .inc_i (state_q == ST_RD_B && rd_vld && tog && !lim && !pair_last),
      .last_o(pair_last)
   );

   always_comb begin
      state_d = state_q;
      verdict = VD_NONE;
      unique case (state_q)
         ST_IDLE: if (go_ok) state_d = ST_RD_A;
         ST_RD_A: if (rd_vld) state_d = ST_RD_B;
         ST_RD_B: if (rd_vld) begin
            if (!tog) begin
               if (sec_tog && erase_q) verdict = VD_SUSP;
               else                    state_d = ST_TAIL;
            end else if (lim) begin
               state_d = ST_RC_A;
            end else if (pair_last) begin
               verdict = VD_FAIL;
            end else begin
               state_d = ST_RD_A;
            end
         end
         ST_RC_A: if (rd_vld) state_d = ST_RC_B;
         ST_RC_B: if (rd_vld) begin
            if (tog)                     verdict = VD_FAIL;
            else if (sec_tog && erase_q) verdict = VD_SUSP;
            else                         state_d = ST_TAIL;
         end
         ST_TAIL: if (rd_vld) verdict = VD_DONE;
         default: state_d = ST_IDLE;
      endcase
      if (verdict != VD_NONE) state_d = ST_IDLE;
   end

   assign rd_start = (state_d != state_q) && (state_d != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         erase_q  <= 1'b0;
         first_q  <= '0;
         result_q <= '0;
         done_q   <= 1'b0;
         fail_q   <= 1'b0;
         susp_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (verdict == VD_DONE);
         fail_q  <= (verdict == VD_FAIL);
         susp_q  <= (verdict == VD_SUSP);
         if (go_ok) begin
            addr_q  <= addr_i;
            erase_q <= erase_i;
         end
         if (rd_vld && (state_q == ST_RD_A || state_q == ST_RC_A))
            first_q <= rd_byte;
         if (verdict != VD_NONE)
            result_q <= rd_byte;
      end
   end

   assign busy_o   = (state_q != ST_IDLE);
   assign done_o   = done_q;
   assign fail_o   = fail_q;
   assign susp_o   = susp_q;
   assign result_o = result_q;
endmodule

// File: rtl/tpc_poll_chk.sv
module tpc_poll_chk #(
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req_o,
   input logic              rd_ack_i,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              fail_o,
   input logic              susp_o
);
   // R1
   idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !rd_req_o);

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> rd_req_o);

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> $stable(rd_addr_o));

   // R10
   verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, fail_o, susp_o}));

   // R10
   verdict_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || fail_o || susp_o) |-> (!busy_o && $past(busy_o)));

   // R10
   verdict_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || fail_o || susp_o) |=> !(done_o || fail_o || susp_o));

   // R11
   go_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(rd_addr_o));
endmodule

bind toggle_poll_ctrl tpc_poll_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_req_o (rd_req_o),
   .rd_ack_i (rd_ack_i),
   .rd_addr_o(rd_addr_o),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .fail_o   (fail_o),
   .susp_o   (susp_o)
);

// File: tb/toggle_poll_ctrl_tb_top.sv
module toggle_poll_ctrl_tb_top;
   localparam int AW = 20;
   localparam int DW = 8;
   localparam int MAXP = 4;

   typedef struct packed {
      logic       erase;
      logic [7:0] tog_n;
      logic [7:0] t2_n;
      logic [7:0] lim_at;
      logic [7:0] done_at;
      logic [1:0] lat;
      logic [1:0] kind;   // 1 done, 2 fail, 3 suspended
      logic [7:0] byte_x;
      logic [7:0] reads_x;
      logic [3:0] req;
   } vec_t;

   // erase tog t2 lim done lat kind byte reads req
   localparam vec_t VECS [8] = '{
      '{1'b0, 8'd0,   8'd0,   8'd255, 8'd0,   2'd0, 2'd1, 8'h81, 8'd3, 4'd3},  // R3 settled at once
      '{1'b0, 8'd4,   8'd0,   8'd255, 8'd4,   2'd1, 2'd1, 8'h81, 8'd7, 4'd4},  // R4 two toggling pairs
      '{1'b0, 8'd255, 8'd0,   8'd255, 8'd255, 2'd2, 2'd2, 8'h40, 8'd8, 4'd7},  // R7 pair cap
      '{1'b0, 8'd2,   8'd0,   8'd1,   8'd2,   2'd0, 2'd1, 8'h81, 8'd5, 4'd5},  // R5 recheck settles
      '{1'b0, 8'd255, 8'd0,   8'd1,   8'd255, 2'd3, 2'd2, 8'h60, 8'd4, 4'd6},  // R6 recheck toggles
      '{1'b1, 8'd0,   8'd255, 8'd255, 8'd255, 2'd1, 2'd3, 8'h04, 8'd2, 4'd8},  // R8 suspended
      '{1'b0, 8'd0,   8'd255, 8'd255, 8'd255, 2'd0, 2'd1, 8'h00, 8'd3, 4'd8},  // R8 erase low: bit 2 ignored
      '{1'b1, 8'd4,   8'd255, 8'd255, 8'd255, 2'd2, 2'd3, 8'h04, 8'd6, 4'd9}   // R9 erasing then suspended
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          go_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          erase_i = 1'b0;
   logic          rd_req_o, rd_ack_i;
   logic [AW-1:0] rd_addr_o;
   logic [DW-1:0] rd_data_i, result_o;
   logic          busy_o, done_o, fail_o, susp_o;

   int   tests = 0, fails = 0;
   vec_t cur;
   int   k = 0, lat_cnt = 0, bad_addr = 0;
   logic [AW-1:0] exp_addr;

   always #10 clk = ~clk;

   toggle_poll_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MAX_PAIRS(MAXP)) dut_i (
      .clk(clk), .rst_n(rst_n), .go_i(go_i), .addr_i(addr_i), .erase_i(erase_i),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
      .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
      .susp_o(susp_o), .result_o(result_o)
   );

   function automatic logic [7:0] byte_at(vec_t v, int idx);
      logic [7:0] b;
      if (idx >= int'(v.done_at)) return 8'h81;
      b = 8'h00;
      b[6] = (idx < int'(v.tog_n)) ? idx[0] : 1'b0;
      b[5] = (idx >= int'(v.lim_at));
      b[2] = (idx < int'(v.t2_n)) ? idx[0] : 1'b0;
      return b;
   endfunction

   // responder: acts on the falling edge
   initial begin
      rd_ack_i = 1'b0;
      rd_data_i = '0;
      forever begin
         @(negedge clk);
         if (rd_ack_i) begin
            rd_ack_i = 1'b0;
            k = k + 1;
         end else if (rd_req_o) begin
            if (lat_cnt >= int'(cur.lat)) begin
               rd_ack_i = 1'b1;
               rd_data_i = byte_at(cur, k);
               lat_cnt = 0;
               if (rd_addr_o != exp_addr) bad_addr = bad_addr + 1;
            end else begin
               lat_cnt = lat_cnt + 1;
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests = tests + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v, input logic [AW-1:0] a, input int extra_go);
      int kind = 0, pulses = 0, cyc = 0;
      cur = v;
      k = 0;
      lat_cnt = 0;
      bad_addr = 0;
      exp_addr = a;
      @(negedge clk);
      go_i = 1'b1; addr_i = a; erase_i = v.erase;
      @(negedge clk);
      go_i = 1'b0; addr_i = ~a; erase_i = ~v.erase;
      // R2 busy rises the cycle after go
      check(busy_o == 1'b1, $sformatf("R2 busy after go (vec req R%0d)", v.req), busy_o, 1);
      while (kind == 0 && cyc < 2000) begin
         if (extra_go != 0 && cyc == extra_go) go_i = 1'b1;
         else go_i = 1'b0;
         if (done_o) kind = 1;
         else if (fail_o) kind = 2;
         else if (susp_o) kind = 3;
         if (kind != 0) begin
            pulses = pulses + 1;
            // R10 busy low in the verdict cycle
            check(busy_o == 1'b0, "R10 busy low at verdict", busy_o, 0);
         end else begin
            @(negedge clk);
            cyc = cyc + 1;
         end
      end
      go_i = 1'b0;
      if (kind == 0) begin
         fails = fails + 1;
         tests = tests + 1;
         $display("FAIL R10 watchdog: no verdict actual=0 expected=%0d", v.kind);
      end
      check(kind == int'(v.kind), $sformatf("R%0d verdict kind", v.req), kind, v.kind);
      check(result_o == v.byte_x, $sformatf("R%0d result byte", v.req), result_o, v.byte_x);
      check(k == int'(v.reads_x), $sformatf("R%0d read count", v.req), k, v.reads_x);
      check(bad_addr == 0, "R2 read address", bad_addr, 0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (done_o || fail_o || susp_o) pulses = pulses + 1;
      end
      check(pulses == 1, "R10 single verdict pulse", pulses, 1);
   endtask

   initial begin
      cur = VECS[0];
      exp_addr = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy_o == 1'b0, "R1 busy in reset", busy_o, 0);
      check(rd_req_o == 1'b0, "R1 req in reset", rd_req_o, 0);
      check({done_o, fail_o, susp_o} == 3'b000, "R1 pulses in reset", {done_o, fail_o, susp_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(busy_o == 1'b0 && rd_req_o == 1'b0, "R1 idle after reset", busy_o, 0);

      for (int i = 0; i < 8; i++) begin
         run_vec(VECS[i], AW'(20'h1_2340 + i), 0);
      end

      // R11 go while busy: the pair-cap vector with a stray go mid-poll
      run_vec(VECS[2], 20'hA_BCDE, 5);
      // R11 stray go right after the first read pair starts
      run_vec(VECS[4], 20'h0_0F0F, 2);
      // R7 counter restarts for a new poll: run the cap vector again
      run_vec(VECS[2], 20'h5_5555, 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(20 * 150000);
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule